// File: doc/BRIEF.md
# Reset-Gated Bus Clock Generator

This block produces the internal bus clock of a small microcontroller. It runs on one fast reference clock. The oscillator clock and the PLL clock arrive as single-cycle tick strobes, and each strobe marks one edge of its source. A select input picks which strobe stream drives the divider. Two cascaded divide-by-two stages then turn the selected stream into a bus clock at one quarter of the source rate.

A power-on or low-voltage reset request stops the bus clock and holds it low, which is its inactive phase. While the request is present and afterwards, an active-low external reset drive is asserted. After the last request cycle, the block counts a fixed number of oscillator ticks. The PLL ticks and the select input have no effect on this count. When the count completes, the reset drive is released and a clock-valid flag is raised in the same cycle. The bus clock then starts from its low phase, so its first edge is rising. A change of the select input is taken up only when the divider wraps, so no bus clock phase is ever shortened.

Top module: `bclk_gen`

## Requirements
- R1: With a steady source, `bus_clk` is low for two selected source ticks and then high for two, giving a period of four ticks.
- R2: The effective source is the oscillator ticks when the effective select is 0 and the PLL ticks when it is 1.
- R3: In the cycle after `por_req` or `lvi_req` is sampled high, `clk_valid` and `rst_out_n` are 0. From the second such held cycle onward, `bus_clk` is 0.
- R4: The hold ends on the `TIMEOUT_TICKS`-th `osc_tick` (default 4096) counted after the last request cycle. `pll_tick` and `clk_sel` do not change this count.
- R5: `rst_out_n` stays 0 for the whole hold, including the cycles where a request is present.
- R6: `clk_valid` and `rst_out_n` rise in the same cycle, and `bus_clk` is 0 in that cycle.
- R7: A request that arrives during the hold restarts the count from zero.
- R8: The effective select is 0 while held. After release it loads `clk_sel` only on the source tick that wraps the divide-by-four cycle, which is the tick that ends a high bus phase.
- R9: `rst_n` low, sampled at a clock edge, puts the block in the held state with the count cleared, just as a power-on request does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator clock edge |
| pll_tick | input | 1 | One-cycle strobe per PLL clock edge |
| clk_sel | input | 1 | Requested source: 0 oscillator, 1 PLL |
| por_req | input | 1 | Power-on reset request, active high |
| lvi_req | input | 1 | Low-voltage reset request, active high |
| bus_clk | output | 1 | Bus clock, low when inactive |
| clk_valid | output | 1 | High once the bus clock is running |
| rst_out_n | output | 1 | Active-low external reset pin drive |

## Verification
The hardest case to reach is a select change that falls exactly on the divider wrap while the PLL and oscillator strobes arrive at unrelated rates, because only a few cycles in each bus period can show an early or late source switch. The bench uses an LFSR to drive long sweeps of the strobe streams and the select input. It checks every cycle against an arithmetic model of the phase counter, the effective select and the timeout count. Directed runs add timeouts with the PLL ticking fast and the select held at 1, and a request injected partway through a count.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
    // Phase of the divide-by-four cycle, built from two divide-by-two stages.
    localparam int DIV_STAGES = 2;
    typedef logic [DIV_STAGES-1:0] div_phase_t;
endpackage

// File: rtl/bclk_timeout.sv
// Reset hold timer.
// A request or a block reset puts the timer in hold and clears its count.
// While in hold and with no request present, it counts oscillator ticks.
// It leaves hold on the TIMEOUT_TICKS-th tick.
// Assumes TIMEOUT_TICKS >= 2.
module bclk_timeout #(
    parameter int TIMEOUT_TICKS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_req,
    input  logic lvi_req,
    input  logic osc_tick,
    output logic hold
);
    localparam int CNT_W = $clog2(TIMEOUT_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt;
    logic             req;

    assign req = por_req | lvi_req;

    // Hold state and oscillator tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n || req) begin
            hold <= 1'b1;
            cnt  <= '0;
        end else if (hold && osc_tick) begin
            if (cnt == LAST) begin
                hold <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_req_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> hold);
    assert_release_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> ($past(osc_tick) && !$past(req)));
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !req) |=> (hold || $past(cnt) == LAST));
endmodule

// File: rtl/bclk_div2.sv
// One divide-by-two stage.
// The output toggles on each enabled cycle.
// carry is high when an enabled cycle moves the output from 1 to 0.
// clr forces the output low, which is the inactive phase.
module bclk_div2 (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic q,
    output logic carry
);
    // Toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= 1'b0;
        else if (en)       q <= ~q;
    end

    // Falling-edge carry into the next stage.
    always_comb carry = en & q;
endmodule

// File: rtl/bclk_srcdiv.sv
// Source select and divide-by-four.
// Selects the oscillator or PLL tick stream and divides it through
// cascaded divide-by-two stages.
// The effective select is 0 while held and is loaded from clk_sel only on
// the wrap tick.
// Assumes the tick strobes are one reference cycle wide.
module bclk_srcdiv
    import bclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clk_sel,
    input  logic osc_tick,
    input  logic pll_tick,
    output logic bus_clk
);
    logic                  eff_sel;
    logic                  src_tick;
    logic [DIV_STAGES:0]   chain;
    div_phase_t            phase;
    logic                  wrap;

    // Tick of the effective source.
    always_comb src_tick = eff_sel ? pll_tick : osc_tick;

    assign chain[0] = src_tick;

    genvar g;
    generate
        for (g = 0; g < DIV_STAGES; g++) begin : g_stage
            bclk_div2 u_div2 (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (hold),
                .en    (chain[g]),
                .q     (phase[g]),
                .carry (chain[g+1])
            );
        end
    endgenerate

    assign wrap    = chain[DIV_STAGES];
    assign bus_clk = phase[DIV_STAGES-1];

    // Effective select, updated only at the divide-cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) eff_sel <= 1'b0;
        else if (wrap)      eff_sel <= clk_sel;
    end

    assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> !bus_clk);
    assert_sel_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_sel != $past(eff_sel) && !$past(hold)) |-> (phase == '0 && $past(wrap)));
    assert_sel_held_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> !eff_sel);
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !src_tick) |=> ($stable(phase) || $past(hold)));
endmodule

// File: rtl/bclk_gen.sv
// Reset-gated bus clock generator top.
// Joins the reset hold timer to the source select and divider.
// The reset pin drive and clk_valid both come from the hold state, so they
// change in the same cycle.
module bclk_gen #(
    parameter int TIMEOUT_TICKS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic pll_tick,
    input  logic clk_sel,
    input  logic por_req,
    input  logic lvi_req,
    output logic bus_clk,
    output logic clk_valid,
    output logic rst_out_n
);
    logic hold;

    bclk_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_req  (por_req),
        .lvi_req  (lvi_req),
        .osc_tick (osc_tick),
        .hold     (hold)
    );

    bclk_srcdiv u_srcdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .clk_sel  (clk_sel),
        .osc_tick (osc_tick),
        .pll_tick (pll_tick),
        .bus_clk  (bus_clk)
    );

    // Status outputs driven from the hold state.
    always_comb begin
        clk_valid = ~hold;
        rst_out_n = ~hold;
    end

    assert_valid_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_valid) |-> ($rose(rst_out_n) && !bus_clk));
    assert_pin_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req || lvi_req) |=> !rst_out_n);
endmodule

// File: tb/bclk_gen_tb.sv
module bclk_gen_tb;
    localparam int T = 4096;

    logic clk = 1'b0;
    logic rst_n, osc_tick, pll_tick, clk_sel, por_req, lvi_req;
    logic bus_clk, clk_valid, rst_out_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state.
    bit       m_hold;
    int       m_cnt;
    bit [1:0] m_phase;
    bit       m_esel;

    always #5 clk = ~clk;

    bclk_gen #(.TIMEOUT_TICKS(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
        .clk_sel(clk_sel), .por_req(por_req), .lvi_req(lvi_req),
        .bus_clk(bus_clk), .clk_valid(clk_valid), .rst_out_n(rst_out_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one cycle of inputs, advance the model, then compare at the negedge.
    task automatic step(input bit o, input bit p, input bit s, input bit por, input bit lvi);
        bit tk, wr, rq;
        osc_tick = o; pll_tick = p; clk_sel = s; por_req = por; lvi_req = lvi;
        @(posedge clk);
        rq = por | lvi;
        tk = m_esel ? p : o;
        wr = !m_hold && tk && (m_phase == 2'd3);
        if (!rst_n || m_hold) begin
            m_phase = 0; m_esel = 0;
        end else begin
            if (tk) m_phase = m_phase + 1;
            if (wr) m_esel = s;
        end
        if (!rst_n || rq) begin
            m_hold = 1; m_cnt = 0;
        end else if (m_hold && o) begin
            if (m_cnt == T - 1) begin m_hold = 0; m_cnt = 0; end
            else m_cnt++;
        end
        @(negedge clk);
        check(bus_clk == m_phase[1], "R1/R2/R8 bus_clk", bus_clk, m_phase[1]);
        check(clk_valid == !m_hold, "R4/R6 clk_valid", clk_valid, !m_hold);
        check(rst_out_n == !m_hold, "R5 rst_out_n", rst_out_n, !m_hold);
    endtask

    // Run with no request until release and count the oscillator ticks given.
    task automatic run_release(input int odiv, input bit p, input bit s, output int pulses);
        pulses = 0;
        for (int i = 0; i < 40000; i++) begin
            bit o;
            if (rst_out_n) break;
            o = (i % odiv) == 0;
            step(o, p, s, 0, 0);
            if (o) pulses++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit [15:0] lf;
        rst_n = 0; osc_tick = 0; pll_tick = 0; clk_sel = 0; por_req = 0; lvi_req = 0;
        m_hold = 1; m_cnt = 0; m_phase = 0; m_esel = 0;
        @(negedge clk); @(negedge clk);
        // R9: block reset puts the design in hold.
        check(rst_out_n == 0, "R9 reset rst_out_n", rst_out_n, 0);
        check(clk_valid == 0, "R9 reset clk_valid", clk_valid, 0);
        check(bus_clk == 0, "R9 reset bus_clk", bus_clk, 0);
        rst_n = 1;

        // R3/R5: a power-on request keeps the hold even while the oscillator ticks.
        for (int i = 0; i < 10; i++) step(1, 1, 1, 1, 0);
        check(rst_out_n == 0, "R5 during request", rst_out_n, 0);

        // R4: the hold ends on exactly T oscillator ticks; the PLL and select are ignored.
        run_release(1, 1, 1, n);
        check(n == T, "R4 timeout osc every cycle", n, T);
        check(bus_clk == 0, "R6 bus low at release", bus_clk, 0);

        // R1: sequence after release with oscillator ticking each cycle, select 0.
        for (int k = 1; k <= 8; k++) begin
            step(1, 0, 0, 0, 0);
            check(bus_clk == ((k >> 1) & 1), "R1 divide by four", bus_clk, (k >> 1) & 1);
        end

        // R2/R8: select PLL mid-cycle, PLL ticks only; no change until the wrap.
        step(1, 0, 1, 0, 0); step(1, 0, 1, 0, 0);   // phase at 2
        for (int k = 0; k < 6; k++) step(0, 1, 1, 0, 0);
        check(bus_clk == 1, "R8 no early switch", bus_clk, 1);
        step(1, 0, 1, 0, 0); step(1, 0, 1, 0, 0);   // wrap, switch to PLL
        for (int k = 1; k <= 4; k++) begin
            step(0, 1, 1, 0, 0);
            check(bus_clk == ((k >> 1) & 1), "R2 PLL source", bus_clk, (k >> 1) & 1);
        end

        // R3: a low-voltage request stops the bus clock.
        step(0, 1, 1, 0, 1);
        step(0, 1, 1, 0, 0);
        check(bus_clk == 0 && rst_out_n == 0, "R3 held after lvi", bus_clk, 0);

        // R7: a request partway through the count restarts it.
        for (int i = 0; i < 2000; i++) step(1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        run_release(3, 1, 1, n);
        check(n == T, "R7 restart count", n, T);

        // R8: the effective select starts at 0 after release even though clk_sel is 1.
        step(0, 1, 1, 0, 0);
        check(bus_clk == 0, "R8 select forced zero", bus_clk, 0);

        // Sweep: LFSR-driven strobes, select and rare requests.
        lf = 16'hACE1;
        for (int i = 0; i < 60000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[5], lf[1] | lf[2], lf[3] ^ lf[9] ? clk_sel : lf[4],
                 lf[15:4] == 12'h0, lf[15:4] == 12'h001);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule